// File: doc/BRIEF.md
# Dual-Input Filtered Capture Timer

This block is a timestamping unit that serves two external capture inputs from one shared free-running counter. The counter advances once per count-enable strobe from an outside prescaler. When a filtered input shows its selected edge, the block copies the current count into a capture register and raises a one-cycle interrupt pulse. Software finds a pulse width by taking the difference of two successive captures. The counter keeps running through every capture.

The mapping between inputs and registers is crossed. Input 0 fills capture register 1 and raises interrupt 1. Input 1 fills capture register 0 and raises interrupt 0. Each raw pin first goes through a synchronizer to the system clock. After that it is sampled only on count-enable cycles. A new level is accepted only when it is seen on two samples in a row, so short glitches cause no capture.

A run control starts the timer. When run is low, the counter is cleared and held at zero, and no capture takes place. When the counter wraps from all ones to zero, it sets a sticky overflow flag. Only a dedicated clear input resets that flag.

Top module: `cap_timer_top`

## Requirements
- R1: On each system clock with `run` high and `tick` high, the counter increases by one, modulo 2^16. A capture never clears or reloads it, so a later capture reads a larger value unless the counter has wrapped.
- R2: A qualified edge on `in0` loads the counter into `cap1` and pulses `irq1`. It changes neither `cap0` nor `irq0`.
- R3: A qualified edge on `in1` loads the counter into `cap0` and pulses `irq0`. It changes neither `cap1` nor `irq1`.
- R4: Edge select encoding, per input (`sel0` for `in0`, `sel1` for `in1`): 2'b00 captures on falling edges, 2'b01 on rising edges, 2'b10 never captures, 2'b11 captures on both edges.
- R5: Inputs are sampled only on cycles where `tick` is high. A pin change with no ticks never causes a capture. The captured value is the count after the tick that accepted the new level.
- R6: A new level must be seen on two successive tick samples before it is accepted. A level that lasts for only one sample is rejected and produces no capture.
- R7: When the counter wraps from 0xFFFF to 0x0000, `ovf` becomes 1 on the next cycle. It then stays 1 until it is cleared.
- R8: A one-cycle pulse on `ovf_clr` clears `ovf` unless a wrap happens in the same cycle. If both happen together, the wrap wins.
- R9: Each `irq` output is high for exactly one system clock per capture. Each capture register keeps its value until the next qualified edge on its input.
- R10: While `run` is low, the counter is cleared and held at 0 and no captures or interrupts happen. Counting restarts from 0 when `run` goes high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Timer run control; low clears and holds the counter |
| tick | input | 1 | Count-enable strobe from the prescaler |
| in0 | input | 1 | Asynchronous capture pin 0 |
| in1 | input | 1 | Asynchronous capture pin 1 |
| sel0 | input | 2 | Edge select for in0 |
| sel1 | input | 2 | Edge select for in1 |
| ovf_clr | input | 1 | Clears the overflow flag |
| cap0 | output | 16 | Capture register 0, loaded by in1 |
| cap1 | output | 16 | Capture register 1, loaded by in0 |
| irq0 | output | 1 | Interrupt pulse for capture register 0 |
| irq1 | output | 1 | Interrupt pulse for capture register 1 |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The overflow wrap is the hardest case to reach from the ports, because it needs 65,536 enabled ticks. The stimulus holds `tick` high continuously with `run` high and checks the flag one tick before the wrap and again just after it. The noise filter is the second difficult case. The bench paces single tick pulses with idle clocks between them, so that a pin level can be shown to exactly one sample and then withdrawn. This exercises rejection of one-sample glitches and the rule that nothing is sampled without a tick.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_OFF  = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cap_free_counter.sv
module cap_free_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic wrap;
  assign wrap = run && tick && (count == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (!run) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end
  end

  // the wrap event takes priority over a clear that arrives in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf <= 1'b0;
    end else if (wrap) begin
      ovf <= 1'b1;
    end else if (ovf_clr) begin
      ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_pin_filter.sv
module cap_pin_filter #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pin,
  output logic rise_p,
  output logic fall_p
);
  logic [SYNC-1:0] sync_q;
  logic            synced;
  logic            samp_q;
  logic            level_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC-2:0], pin};
  end
  assign synced = sync_q[SYNC-1];

  // a new level is accepted only when two successive tick samples agree on it
  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q  <= 1'b0;
      level_q <= 1'b0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
      if (tick) begin
        samp_q <= synced;
        if (synced == samp_q && synced != level_q) begin
          level_q <= synced;
          rise_p  <= synced;
          fall_p  <= !synced;
        end
      end
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         rise_p,
  input  logic         fall_p,
  input  edge_sel_e    sel,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap,
  output logic         irq
);
  logic hit;
  logic qual;

  always_comb begin
    case (sel)
      EDGE_FALL: hit = fall_p;
      EDGE_RISE: hit = rise_p;
      EDGE_BOTH: hit = rise_p | fall_p;
      default:   hit = 1'b0;
    endcase
  end
  assign qual = run & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
      irq <= 1'b0;
    end else begin
      irq <= qual;
      if (qual) cap <= count;
    end
  end
endmodule

// File: rtl/cap_timer_top.sv
module cap_timer_top
  import cap_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic         in0,
  input  logic         in1,
  input  logic [1:0]   sel0,
  input  logic [1:0]   sel1,
  input  logic         ovf_clr,
  output logic [W-1:0] cap0,
  output logic [W-1:0] cap1,
  output logic         irq0,
  output logic         irq1,
  output logic         ovf
);
  localparam int NCH = 2;

  logic [W-1:0]   cnt_q;
  logic [NCH-1:0] pin_vec;
  logic [1:0]     sel_vec [NCH];
  logic [NCH-1:0] rise_vec, fall_vec, irq_vec;
  logic [W-1:0]   cap_vec [NCH];

  assign pin_vec    = {in1, in0};
  assign sel_vec[0] = sel0;
  assign sel_vec[1] = sel1;

  cap_free_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .ovf_clr(ovf_clr),
    .count(cnt_q), .ovf(ovf)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cap_pin_filter #(.SYNC(SYNC)) u_flt (
      .clk(clk), .rst(rst), .tick(tick), .pin(pin_vec[i]),
      .rise_p(rise_vec[i]), .fall_p(fall_vec[i])
    );
    cap_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .run(run),
      .rise_p(rise_vec[i]), .fall_p(fall_vec[i]),
      .sel(edge_sel_e'(sel_vec[i])), .count(cnt_q),
      .cap(cap_vec[i]), .irq(irq_vec[i])
    );
  end

  // crossed mapping: input 0 feeds register 1, input 1 feeds register 0
  assign cap1 = cap_vec[0];
  assign irq1 = irq_vec[0];
  assign cap0 = cap_vec[1];
  assign irq0 = irq_vec[1];
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         tick,
  input logic         ovf_clr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cap0,
  input logic [W-1:0] cap1,
  input logic         irq0,
  input logic         irq1,
  input logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> cnt == W'($past(cnt) + 1'b1)); // R1
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == '0); // R10
  AST_STOP_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    !run |=> !irq0 && !irq1); // R10
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt == TOP) |=> ovf); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(run && tick && cnt == TOP)) |=> !ovf); // R8
  AST_IRQ0_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq0 |=> !irq0); // R9
  AST_IRQ1_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq1 |=> !irq1); // R9
  AST_CAP0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap0) |-> irq0); // R9
  AST_CAP1_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap1) |-> irq1); // R9
endmodule

bind cap_timer_top cap_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .tick(tick), .ovf_clr(ovf_clr),
  .cnt(cnt_q), .cap0(cap0), .cap1(cap1), .irq0(irq0), .irq1(irq1), .ovf(ovf)
);

// File: tb/sim_cap_timer_top.sv
module sim_cap_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        tick = 1'b0;
  logic        in0 = 1'b0;
  logic        in1 = 1'b0;
  logic [1:0]  sel0 = 2'b01;
  logic [1:0]  sel1 = 2'b01;
  logic        ovf_clr = 1'b0;
  logic [15:0] cap0, cap1;
  logic        irq0, irq1, ovf;

  int n_run = 0;
  int n_fail = 0;
  int n_irq0 = 0;
  int n_irq1 = 0;
  int n_wide = 0;
  logic [15:0] mcnt = '0;
  logic prev0 = 1'b0;
  logic prev1 = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  cap_timer_top u0 (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .in0(in0), .in1(in1),
    .sel0(sel0), .sel1(sel1), .ovf_clr(ovf_clr),
    .cap0(cap0), .cap1(cap1), .irq0(irq0), .irq1(irq1), .ovf(ovf)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (irq0) n_irq0++;
      if (irq1) n_irq1++;
      if ((irq0 && prev0) || (irq1 && prev1)) n_wide++;
    end
    prev0 = irq0;
    prev1 = irq1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one tick pulse followed by idle clocks; the model counter follows it
  task automatic step();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    if (run) mcnt = mcnt + 1'b1;
    idle(2);
  endtask

  task automatic settle_pin();
    idle(3);
    step();
    step();
    idle(2);
  endtask

  task automatic t_reset();
    chk(cap0 == 0, "R9 reset cap0", cap0, 0);
    chk(cap1 == 0, "R9 reset cap1", cap1, 0);
    chk(!irq0 && !irq1, "R9 reset irq", {irq1, irq0}, 0);
    chk(!ovf, "R7 reset ovf", ovf, 0);
  endtask

  task automatic t_cross();
    int a0, a1;
    logic [15:0] first;
    @(negedge clk) run = 1'b1;
    mcnt = '0;
    sel0 = 2'b01; sel1 = 2'b01;
    repeat (4) step();
    a0 = n_irq0; a1 = n_irq1;
    in0 = 1'b1;
    settle_pin();
    chk(n_irq1 == a1 + 1, "R2 irq1 count", n_irq1, a1 + 1);
    chk(n_irq0 == a0, "R2 irq0 quiet", n_irq0, a0);
    chk(cap1 == mcnt, "R2 cap1 value", cap1, mcnt);
    chk(cap0 == 0, "R2 cap0 untouched", cap0, 0);
    first = cap1;
    repeat (5) step();
    in1 = 1'b1;
    settle_pin();
    chk(n_irq0 == a0 + 1, "R3 irq0 count", n_irq0, a0 + 1);
    chk(n_irq1 == a1 + 1, "R3 irq1 quiet", n_irq1, a1 + 1);
    chk(cap0 == mcnt, "R3 cap0 value", cap0, mcnt);
    chk(cap1 == first, "R9 cap1 holds", cap1, first);
    chk(cap0 > cap1, "R1 counter kept running", cap0, cap1);
  endtask

  task automatic t_sample_only();
    int a1;
    sel0 = 2'b11;
    a1 = n_irq1;
    in0 = 1'b0;
    idle(20);
    chk(n_irq1 == a1, "R5 no capture without ticks", n_irq1, a1);
    step();
    idle(2);
    chk(n_irq1 == a1, "R6 one sample not enough", n_irq1, a1);
    step();
    idle(2);
    chk(n_irq1 == a1 + 1, "R5 capture after second tick", n_irq1, a1 + 1);
    chk(cap1 == mcnt, "R5 capture value", cap1, mcnt);
  endtask

  task automatic t_glitch();
    int a1;
    logic [15:0] held;
    a1 = n_irq1;
    held = cap1;
    in0 = 1'b1;
    idle(3);
    step();
    in0 = 1'b0;
    idle(3);
    step();
    step();
    step();
    chk(n_irq1 == a1, "R6 glitch rejected", n_irq1, a1);
    chk(cap1 == held, "R6 cap1 unchanged by glitch", cap1, held);
  endtask

  task automatic t_edge_sel();
    int a1;
    sel0 = 2'b00;
    a1 = n_irq1;
    in0 = 1'b1;
    settle_pin();
    chk(n_irq1 == a1, "R4 falling mode ignores rise", n_irq1, a1);
    in0 = 1'b0;
    settle_pin();
    chk(n_irq1 == a1 + 1, "R4 falling mode captures fall", n_irq1, a1 + 1);
    chk(cap1 == mcnt, "R4 falling capture value", cap1, mcnt);
    sel0 = 2'b10;
    in0 = 1'b1;
    settle_pin();
    in0 = 1'b0;
    settle_pin();
    chk(n_irq1 == a1 + 1, "R4 disabled mode no capture", n_irq1, a1 + 1);
    sel0 = 2'b11;
    in0 = 1'b1;
    settle_pin();
    chk(n_irq1 == a1 + 2, "R4 both mode captures rise", n_irq1, a1 + 2);
    chk(cap1 == mcnt, "R4 both mode value", cap1, mcnt);
    sel0 = 2'b01;
    in0 = 1'b0;
    settle_pin();
    chk(n_irq1 == a1 + 2, "R4 rising mode ignores fall", n_irq1, a1 + 2);
  endtask

  task automatic t_stop();
    int a0;
    logic [15:0] held;
    sel1 = 2'b11;
    @(negedge clk) run = 1'b0;
    mcnt = '0;
    a0 = n_irq0;
    held = cap0;
    in1 = 1'b0;
    settle_pin();
    in1 = 1'b1;
    settle_pin();
    chk(n_irq0 == a0, "R10 no capture while stopped", n_irq0, a0);
    chk(cap0 == held, "R10 cap0 held while stopped", cap0, held);
    @(negedge clk) run = 1'b1;
    repeat (3) step();
    in1 = 1'b0;
    settle_pin();
    chk(n_irq0 == a0 + 1, "R10 capture after restart", n_irq0, a0 + 1);
    chk(cap0 == mcnt, "R10 count restarted from zero", cap0, mcnt);
  endtask

  task automatic t_ovf();
    @(negedge clk) run = 1'b0;
    @(negedge clk) run = 1'b1;
    tick = 1'b1;
    repeat (65535) @(negedge clk);
    chk(!ovf, "R7 no flag before wrap", ovf, 0);
    @(negedge clk) tick = 1'b0;
    chk(ovf, "R7 flag on wrap", ovf, 1);
    idle(10);
    chk(ovf, "R7 flag sticky", ovf, 1);
    ovf_clr = 1'b1;
    @(negedge clk) ovf_clr = 1'b0;
    chk(!ovf, "R8 clear input", ovf, 0);
    idle(5);
    chk(!ovf, "R8 stays clear", ovf, 0);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_cross();
    t_sample_only();
    t_glitch();
    t_edge_sel();
    t_stop();
    t_ovf();
    chk(n_wide == 0, "R9 interrupts one cycle wide", n_wide, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule